// File: doc/BRIEF.md
# Lockstep Compare and Retry Controller

Two identical execution units run the same instruction stream. Each presents a retirement strobe with a destination register index and a result value, and this controller compares the two units every cycle. When both retire the same register write, the write is committed to the outside world in the same cycle. The write is also stored into a SECDED-protected checkpoint register file, which therefore always trails the executing units by exactly one instruction.

Any disagreement is treated first as a transient. The controller stalls, streams the checkpoint back to the units over a restore port, and pulses a retry strobe so the instruction is executed again. If the retried instruction disagrees again before any clean retirement, the fault is declared permanent. The corrected checkpoint is then scanned out, register by register, to a spare unit, and the controller halts. An uncorrectable error found in the checkpoint while it is being read also diverts the controller into the scan-out and halt path. In that case it makes a best effort to gather the state rather than retry. Logic downstream of the commit port only ever sees the stall as added latency.

A write-side XOR mask lets a test corrupt the codeword being stored, so the correction and detection paths can be exercised at the ports.

Top module: `lockstep_retry_ctrl`

## Requirements
- R1: In run state, a cycle where both units assert valid with equal register index and equal data raises commit_o in that same cycle, with that index and data. The checkpoint entry at that index takes the data.
- R2: A cycle is a mismatch when exactly one unit asserts valid, or when both assert valid with differing index or data. A mismatch never raises commit_o, and stall_o is high in the next cycle.
- R3: A mismatch while the retry count is below RETRY_LIMIT (default 1) starts a restore in the next cycle. The restore lasts NREG cycles with restore_vld_o high, ckpt_addr_o stepping 0 to NREG-1, and ckpt_data_o equal to the last committed value of each register (zero if never written). retry_o is high only in the final restore cycle, and run resumes in the cycle after it.
- R4: Any clean retirement (R1) clears the retry count, so a later mismatch is again handled as a transient (R3).
- R5: A mismatch while the retry count equals RETRY_LIMIT sets hard_fault_o. NREG scan cycles follow with scan_vld_o high and ckpt_addr_o stepping 0 to NREG-1 with the checkpoint data, and then halted_o rises. hard_fault_o stays set until reset.
- R6: stall_o is high in every state but run. While stalled, unit inputs are ignored: no commit occurs and no checkpoint entry changes.
- R7: Stored words are SECDED codewords. Codeword bit 0 is the overall parity, and bits 1 to 38 are Hamming positions with check bits at the power-of-two positions. A single flipped bit (for example bit 3, flipped through inj_mask_i at write time) is corrected on read, and ckpt_fail_o stays low.
- R8: Two flipped bits in a word (for example bits 1 and 2) are detected when the word is read during restore or scan, and this sets ckpt_fail_o. A restore that saw such a word ends without retry_o, goes on to the full scan-out, and then halts. hard_fault_o stays low.
- R9: After reset the controller is in run state. stall_o, retry_o, commit_o, restore_vld_o, scan_vld_o, hard_fault_o, ckpt_fail_o and halted_o are all low, and every checkpoint entry reads as zero.
- R10: Once halted, the controller stays halted with stall_o high. It raises no commit_o, restore_vld_o or scan_vld_o until reset, whatever the unit inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_vld_i | input | 1 | Unit A retirement strobe |
| a_addr_i | input | AW | Unit A destination register index |
| a_data_i | input | DATA_W | Unit A result |
| b_vld_i | input | 1 | Unit B retirement strobe |
| b_addr_i | input | AW | Unit B destination register index |
| b_data_i | input | DATA_W | Unit B result |
| inj_mask_i | input | CW | XOR mask applied to the codeword written on a commit |
| commit_o | output | 1 | Agreed retirement committed this cycle |
| commit_addr_o | output | AW | Committed register index |
| commit_data_o | output | DATA_W | Committed data |
| stall_o | output | 1 | Holds retirements and external commits |
| retry_o | output | 1 | Re-execute the last instruction |
| restore_vld_o | output | 1 | Restore stream beat valid |
| scan_vld_o | output | 1 | Scan-out stream beat valid |
| ckpt_addr_o | output | AW | Register index of the current stream beat |
| ckpt_data_o | output | DATA_W | Corrected checkpoint data of the current beat |
| hard_fault_o | output | 1 | Permanent fault declared |
| ckpt_fail_o | output | 1 | Uncorrectable checkpoint error seen |
| halted_o | output | 1 | Controller stopped after scan-out |

## Verification
The assertions take for granted that the unit inputs are never X after reset. They also assume that the units repeat the mismatching instruction only after retry_o, and that inj_mask_i flips no more than two bits of any single word. The bench drives its inputs at the falling edge, holds inj_mask_i at zero except during the single directed write it targets, and uses one- and two-bit masks only. The random phase injects a mismatch only when the model's retry count is zero, so that any hard fault comes from the directed sequences alone.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_RESTORE, ST_SCAN, ST_HALT} rec_state_e;

  function automatic int ecc_pbits(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic int ecc_cw(int dw);
    return dw + ecc_pbits(dw) + 1;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DW = 32,
  localparam int P = lsr_pkg::ecc_pbits(DW),
  localparam int N = DW + P,
  localparam int CW = N + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    int d;
    logic [CW-1:0] c;
    c = '0;
    d = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = data_i[d];
        d++;
      end
    end
    for (int i = 0; i < P; i++) begin
      for (int pos = 1; pos <= N; pos++) begin
        if (((pos >> i) & 1) == 1 && pos != (1 << i)) c[1 << i] = c[1 << i] ^ c[pos];
      end
    end
    c[0] = ^c[N:1];
    code_o = c;
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DW = 32,
  localparam int P = lsr_pkg::ecc_pbits(DW),
  localparam int N = DW + P,
  localparam int CW = N + 1
) (
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          ce_o,
  output logic          ue_o
);
  logic [P-1:0]  syn;
  logic          ovr;
  logic [CW-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int pos = 1; pos <= N; pos++) begin
      if (code_i[pos]) syn = syn ^ pos[P-1:0];
    end
    ovr = ^code_i;
    fixed = code_i;
    // odd overall parity: one bit flipped, syndrome names it (0 = parity bit)
    for (int pos = 0; pos <= N; pos++) begin
      if (ovr && int'(syn) == pos) fixed[pos] = ~fixed[pos];
    end
    ce_o = ovr && int'(syn) <= N;
    ue_o = (!ovr && syn != '0) || (ovr && int'(syn) > N);
  end

  always_comb begin
    int d;
    data_o = '0;
    d = 0;
    for (int pos = 1; pos <= N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        data_o[d] = fixed[pos];
        d++;
      end
    end
  end
endmodule

// File: rtl/ckpt_store.sv
module ckpt_store #(
  parameter int DW = 32,
  parameter int NREG = 8,
  localparam int AW = $clog2(NREG),
  localparam int CW = lsr_pkg::ecc_cw(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] inj_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          ue_o
);
  logic [CW-1:0] mem_q [NREG];
  logic [CW-1:0] wcode;
  logic          ce;

  secded_enc #(.DW(DW)) u_enc (.data_i(wdata_i), .code_o(wcode));

  // all-zero word is a valid codeword of zero data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wcode ^ inj_i;
    end
  end

  secded_dec #(.DW(DW)) u_dec (
    .code_i(mem_q[raddr_i]), .data_o(rdata_o), .ce_o(ce), .ue_o(ue_o)
  );

  AST_ECC_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce && ue_o)); // R7
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          a_vld_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_data_i,
  input  logic          b_vld_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_data_i,
  output logic          agree_o,
  output logic          mis_o
);
  logic same;
  assign same    = (a_addr_i == b_addr_i) && (a_data_i == b_data_i);
  assign agree_o = a_vld_i && b_vld_i && same;
  assign mis_o   = (a_vld_i != b_vld_i) || (a_vld_i && b_vld_i && !same);
endmodule

// File: rtl/lockstep_retry_ctrl.sv
module lockstep_retry_ctrl #(
  parameter int DATA_W = 32,
  parameter int NREG = 8,
  parameter int RETRY_LIMIT = 1,
  localparam int AW = $clog2(NREG),
  localparam int CW = lsr_pkg::ecc_cw(DATA_W),
  localparam int RW = $clog2(RETRY_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_vld_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              b_vld_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [CW-1:0]     inj_mask_i,
  output logic              commit_o,
  output logic [AW-1:0]     commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              stall_o,
  output logic              retry_o,
  output logic              restore_vld_o,
  output logic              scan_vld_o,
  output logic [AW-1:0]     ckpt_addr_o,
  output logic [DATA_W-1:0] ckpt_data_o,
  output logic              hard_fault_o,
  output logic              ckpt_fail_o,
  output logic              halted_o
);
  import lsr_pkg::*;

  rec_state_e  state_q;
  logic [AW-1:0] idx_q;
  logic [RW-1:0] rcnt_q;
  logic        hard_q, fail_q;
  logic        agree, mis, run, last, rd_ue, streaming;

  lockstep_cmp #(.DW(DATA_W), .AW(AW)) u_cmp (
    .a_vld_i(a_vld_i), .a_addr_i(a_addr_i), .a_data_i(a_data_i),
    .b_vld_i(b_vld_i), .b_addr_i(b_addr_i), .b_data_i(b_data_i),
    .agree_o(agree), .mis_o(mis)
  );

  assign run       = (state_q == ST_RUN);
  assign last      = (idx_q == AW'(NREG - 1));
  assign streaming = (state_q == ST_RESTORE) || (state_q == ST_SCAN);
  assign commit_o  = run && agree;

  ckpt_store #(.DW(DATA_W), .NREG(NREG)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(commit_o), .waddr_i(a_addr_i),
    .wdata_i(a_data_i), .inj_i(inj_mask_i), .raddr_i(idx_q),
    .rdata_o(ckpt_data_o), .ue_o(rd_ue)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      rcnt_q  <= '0;
      hard_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      if (streaming && rd_ue) fail_q <= 1'b1;
      unique case (state_q)
        ST_RUN: begin
          idx_q <= '0;
          if (mis) begin
            if (int'(rcnt_q) < RETRY_LIMIT) begin
              rcnt_q  <= rcnt_q + 1'b1;
              state_q <= ST_RESTORE;
            end else begin
              hard_q  <= 1'b1;
              state_q <= ST_SCAN;
            end
          end else if (agree) begin
            rcnt_q <= '0;
          end
        end
        ST_RESTORE: begin
          idx_q <= idx_q + 1'b1;
          if (last) begin
            idx_q   <= '0;
            // corrupted checkpoint: gather what is left instead of retrying
            state_q <= (fail_q || rd_ue) ? ST_SCAN : ST_RUN;
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (last) begin
            idx_q   <= '0;
            state_q <= ST_HALT;
          end
        end
        default: ;
      endcase
    end
  end

  assign commit_addr_o = a_addr_i;
  assign commit_data_o = a_data_i;
  assign stall_o       = !run;
  assign retry_o       = (state_q == ST_RESTORE) && last && !(fail_q || rd_ue);
  assign restore_vld_o = (state_q == ST_RESTORE);
  assign scan_vld_o    = (state_q == ST_SCAN);
  assign ckpt_addr_o   = idx_q;
  assign hard_fault_o  = hard_q;
  assign ckpt_fail_o   = fail_q;
  assign halted_o      = (state_q == ST_HALT);

  AST_MISMATCH_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && mis) |=> stall_o); // R2
  AST_NO_COMMIT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !commit_o); // R6
  AST_RETRY_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !stall_o); // R3
  AST_ONE_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restore_vld_o && scan_vld_o)); // R3
  AST_HARD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_fault_o |=> hard_fault_o); // R5
  AST_FAIL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_fail_o |=> (ckpt_fail_o && !retry_o)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && stall_o && !scan_vld_o && !restore_vld_o)); // R10
endmodule

// File: tb/tb_lockstep_retry_ctrl.sv
module tb_lockstep_retry_ctrl;
  localparam int CLK_P  = 10;
  localparam int DW     = 32;
  localparam int NREG   = 8;
  localparam int AW     = $clog2(NREG);
  localparam int CW     = lsr_pkg::ecc_cw(DW);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic a_vld_i, b_vld_i;
  logic [AW-1:0] a_addr_i, b_addr_i;
  logic [DW-1:0] a_data_i, b_data_i;
  logic [CW-1:0] inj_mask_i;
  logic commit_o, stall_o, retry_o, restore_vld_o, scan_vld_o;
  logic hard_fault_o, ckpt_fail_o, halted_o;
  logic [AW-1:0] commit_addr_o, ckpt_addr_o;
  logic [DW-1:0] commit_data_o, ckpt_data_o;

  lockstep_retry_ctrl dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int tests = 0, fails = 0;
  logic [DW-1:0] exp_q [NREG];
  int rcnt;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input logic bv, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                       input logic [CW-1:0] m);
    @(negedge clk_i);
    a_vld_i = av; a_addr_i = aa; a_data_i = ad;
    b_vld_i = bv; b_addr_i = ba; b_data_i = bd;
    inj_mask_i = m;
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    a_vld_i = 0; b_vld_i = 0; a_addr_i = '0; b_addr_i = '0;
    a_data_i = '0; b_data_i = '0; inj_mask_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NREG; i++) exp_q[i] = '0;
    rcnt = 0;
  endtask

  task automatic agree(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] m);
    drive(1, a, d, 1, a, d, m);
    chk(commit_o && commit_addr_o == a && commit_data_o == d, "R1 commit", {31'd0, commit_o, commit_data_o}, {32'd1, d});
    exp_q[a] = d;
    rcnt = 0;
  endtask

  task automatic mismatch(input int kind);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    a = AW'($urandom);
    d = $urandom;
    case (kind)
      0: drive(1, a, d, 1, a, d ^ 32'h10, '0);
      1: drive(1, a, d, 1, a + 1'b1, d, '0);
      2: drive(1, a, d, 0, a, d, '0);
      default: drive(0, a, d, 1, a, d, '0);
    endcase
    chk(!commit_o && !stall_o, "R2 no commit on mismatch", {63'd0, commit_o}, 64'd0);
  endtask

  // stream check: scan=0 restore, scan=1 scan-out; skip = index with corrupt data
  task automatic stream(input logic scan, input logic exp_retry, input int skip, input logic junk);
    for (int i = 0; i < NREG; i++) begin
      if (junk) drive(1, AW'(i), 32'hdead0000 | i, 1, AW'(i), 32'hdead0000 | i, '0);
      else drive(0, '0, '0, 0, '0, '0, '0);
      if (scan) chk(scan_vld_o && !restore_vld_o, "R5 scan valid", {62'd0, scan_vld_o, restore_vld_o}, 64'd2);
      else chk(restore_vld_o && !scan_vld_o, "R3 restore valid", {62'd0, restore_vld_o, scan_vld_o}, 64'd2);
      chk(ckpt_addr_o == AW'(i), "R3 stream order", 64'(ckpt_addr_o), 64'(i));
      if (i != skip)
        chk(ckpt_data_o == exp_q[i], scan ? "R5 scan data" : "R3 restore data", 64'(ckpt_data_o), 64'(exp_q[i]));
      chk(stall_o && !commit_o, "R6 stalled, no commit", {62'd0, stall_o, commit_o}, 64'd2);
      chk(retry_o == ((i == NREG - 1) && exp_retry && !scan), "R3 retry strobe", 64'(retry_o), 64'((i == NREG - 1) && exp_retry && !scan));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    drive(0, '0, '0, 0, '0, '0, '0);
    chk({stall_o, retry_o, commit_o, restore_vld_o, scan_vld_o, hard_fault_o, ckpt_fail_o, halted_o} == 8'd0,
        "R9 reset outputs", {56'd0, stall_o, retry_o, commit_o, restore_vld_o, scan_vld_o, hard_fault_o, ckpt_fail_o, halted_o}, 64'd0);
    // R9: checkpoint reads zero after reset
    mismatch(0);
    stream(0, 1, -1, 0);
    rcnt = 1;
    agree(3, 32'h1234_5678, '0);

    // random phase: R1, R2, R3, R4
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 16;
      if (r < 10) agree(AW'($urandom), $urandom, '0);
      else if (r < 14 || rcnt != 0) begin
        drive(0, '0, '0, 0, '0, '0, '0);
        chk(!commit_o && !stall_o, "R1 idle no commit", {62'd0, commit_o, stall_o}, 64'd0);
      end else begin
        mismatch(r % 4);
        stream(0, 1, -1, (r % 2) == 1);
        rcnt = 1;
      end
    end

    // R4: clean retirement after a retry clears the count
    agree(1, 32'haaaa_0001, '0);
    mismatch(0);
    stream(0, 1, -1, 0);
    agree(2, 32'hbbbb_0002, '0);
    mismatch(1);
    stream(0, 1, -1, 1);
    chk(!hard_fault_o, "R4 second transient not hard", 64'(hard_fault_o), 64'd0);

    // R5: retried instruction disagrees again
    mismatch(2);
    chk(!hard_fault_o, "R5 not yet hard", 64'(hard_fault_o), 64'd0);
    drive(0, '0, '0, 0, '0, '0, '0);
    chk(hard_fault_o && scan_vld_o, "R5 hard fault raised", {62'd0, hard_fault_o, scan_vld_o}, 64'd3);
    @(posedge clk_i);
    // back up: first scan beat already seen, rerun stream from a fresh reset case below
    for (int i = 1; i < NREG; i++) begin
      drive(1, AW'(i), 32'h5, 1, AW'(i), 32'h5, '0);
      chk(scan_vld_o && ckpt_addr_o == AW'(i) && ckpt_data_o == exp_q[i], "R5 scan data",
          64'(ckpt_data_o), 64'(exp_q[i]));
      chk(!commit_o, "R6 no commit during scan", 64'(commit_o), 64'd0);
    end
    for (int i = 0; i < 4; i++) begin
      drive(1, AW'(i), 32'h77, 1, AW'(i), 32'h77, '0);
      chk(halted_o && stall_o && !commit_o && !scan_vld_o && !restore_vld_o, "R10 halted holds",
          {59'd0, halted_o, stall_o, commit_o, scan_vld_o, restore_vld_o}, 64'h18);
    end
    chk(hard_fault_o && !ckpt_fail_o, "R5 flags", {62'd0, hard_fault_o, ckpt_fail_o}, 64'd2);

    // R7: single-bit flip corrected
    do_reset();
    for (int i = 0; i < NREG; i++) agree(AW'(i), $urandom, '0);
    agree(5, 32'hcafe_f00d, CW'(1) << 3);
    mismatch(3);
    stream(0, 1, -1, 0);
    drive(0, '0, '0, 0, '0, '0, '0);
    chk(!ckpt_fail_o && !stall_o, "R7 corrected, no fail", {62'd0, ckpt_fail_o, stall_o}, 64'd0);

    // R8: double-bit flip detected, restore diverts to scan then halt
    do_reset();
    for (int i = 0; i < NREG; i++) agree(AW'(i), $urandom, '0);
    agree(2, 32'h0bad_0bad, CW'(3) << 1);
    mismatch(0);
    stream(0, 0, 2, 0);
    chk(ckpt_fail_o, "R8 fail flag set", 64'(ckpt_fail_o), 64'd1);
    stream(1, 0, 2, 1);
    drive(0, '0, '0, 0, '0, '0, '0);
    chk(halted_o && ckpt_fail_o && !hard_fault_o, "R8 halt without hard fault",
        {61'd0, halted_o, ckpt_fail_o, hard_fault_o}, 64'd6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule